// File: doc/BRIEF.md
# I/Q Envelope Bit Detector

This block turns a stream of signed I/Q correlator samples into one decided bit per bit window. A strobe marks the start of each window. The block then counts the valid sample pairs that follow. The first pairs settle the correlator and are thrown away. The next group of pairs is summed, with I and Q in two separate signed accumulators. Every pair after that group is ignored until the next strobe.

When the last summed pair arrives, the block estimates the subcarrier envelope from the two sums without a square root. It takes the larger absolute sum and adds half of the smaller one. It divides that estimate by the number of summed pairs, which turns it into a per-sample level, and compares the level against a threshold. A keystream bit can be XORed onto the decision to undo bitwise obfuscation on the link. The decided bit and the envelope estimate are held at the outputs, and a one-cycle `done_o` pulse marks each new result.

With the defaults, a window holds 21 pairs. Pairs 0 to 4 are skipped, pairs 5 to 12 are summed, and pairs 13 to 20 are unused.

Top module: `iq_env_bit_det`

## Requirements
- R1: While rst_ni is low and after its release, bit_o, done_o and amp_o are all 0.
- R2: A window begins on a cycle with win_start_i high; a pair presented with the strobe counts as pair 0. Cycles with smp_valid_i low are not counted. Pairs arriving after reset and before the first strobe produce no result.
- R3: The first SKIP_N (default 5) counted pairs of a window do not contribute to the result.
- R4: The next AVG_N (default 8) counted pairs are summed, with I and Q in separate two's-complement accumulators. Eight samples of -128 on both channels give a correct result with no overflow.
- R5: Pairs after the last summed pair produce no further done_o, and bit_o and amp_o stay unchanged until the next window completes.
- R6: amp_o = max(|sumI|,|sumQ|) + floor(min(|sumI|,|sumQ|)/2).
- R7: The detected bit is 1 exactly when (amp >> log2(AVG_N)) is strictly greater than THRESH (default 8), and 0 otherwise.
- R8: When ks_en_i is high in the cycle of the last summed pair, bit_o is the detected bit XOR ks_bit_i from that cycle. When ks_en_i is low, ks_bit_i has no effect.
- R9: done_o is high for exactly one cycle, beginning at the clock edge that accepts the last summed pair. bit_o and amp_o take their new values at that same edge.
- R10: A strobe in the middle of a window discards the partial count and the partial sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_start_i | input | 1 | Start-of-window strobe |
| smp_valid_i | input | 1 | Qualifies smp_i_i and smp_q_i |
| smp_i_i | input | SAMPLE_W | Signed I sample |
| smp_q_i | input | SAMPLE_W | Signed Q sample |
| ks_en_i | input | 1 | Enables keystream XOR |
| ks_bit_i | input | 1 | Keystream bit |
| bit_o | output | 1 | Decided bit, held between results |
| done_o | output | 1 | One-cycle result pulse |
| amp_o | output | SAMPLE_W+log2(AVG_N)+1 | Envelope estimate of the last window |

## Verification
Each result is due at the rising edge that accepts the last summed pair, so done_o, bit_o and amp_o are valid one edge after that pair is driven. The bench drives every input on the falling edge and samples 1 ns after the rising edge that follows the final summed pair. It checks the fall of done_o after the next accepted pair, and it checks that the outputs are still unchanged once the unused tail of the window has been fed. Windows with idle cycles between pairs move the due edge to the cycle of the final valid pair rather than a fixed offset from the strobe. The bench follows this by tracking the pair index, not a cycle count.

// File: rtl/iq_env_pkg.sv
package iq_env_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SKIP = 2'd1,
    PH_SUM  = 2'd2,
    PH_DONE = 2'd3
  } win_ph_e;
endpackage

// File: rtl/iq_win_acc.sv
module iq_win_acc
  import iq_env_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int SKIP_N   = 5,
  parameter int AVG_N    = 8,
  parameter int ACC_W    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] i_i,
  input  logic [SAMPLE_W-1:0] q_i,
  output logic [ACC_W-1:0]    sum_i_o,
  output logic [ACC_W-1:0]    sum_q_o,
  output logic                last_o
);
  localparam int CNT_MAX   = (SKIP_N > AVG_N) ? SKIP_N : AVG_N;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int SKIP_LAST = (SKIP_N > 0) ? SKIP_N - 1 : 0;
  localparam win_ph_e PH_FIRST = (SKIP_N > 0) ? PH_SKIP : PH_SUM;

  win_ph_e            ph_q, ph_b, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_b, cnt_d;
  logic [ACC_W-1:0]   acc_i_q, acc_q_q, base_i, base_q, ext_i, ext_q;
  logic               add;

  always_comb begin
    // strobe restarts the window in the same cycle it arrives
    ph_b   = start_i ? PH_FIRST : ph_q;
    cnt_b  = start_i ? '0 : cnt_q;
    base_i = start_i ? '0 : acc_i_q;
    base_q = start_i ? '0 : acc_q_q;
    ext_i  = {{(ACC_W-SAMPLE_W){i_i[SAMPLE_W-1]}}, i_i};
    ext_q  = {{(ACC_W-SAMPLE_W){q_i[SAMPLE_W-1]}}, q_i};
    add    = valid_i && (ph_b == PH_SUM);
    sum_i_o = add ? base_i + ext_i : base_i;
    sum_q_o = add ? base_q + ext_q : base_q;
    ph_d   = ph_b;
    cnt_d  = cnt_b;
    last_o = 1'b0;
    if (valid_i) begin
      case (ph_b)
        PH_SKIP: begin
          if (cnt_b == CNT_W'(SKIP_LAST)) begin
            ph_d  = PH_SUM;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_b + 1'b1;
          end
        end
        PH_SUM: begin
          if (cnt_b == CNT_W'(AVG_N - 1)) begin
            ph_d   = PH_DONE;
            cnt_d  = '0;
            last_o = 1'b1;
          end else begin
            cnt_d = cnt_b + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      acc_i_q <= '0;
      acc_q_q <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      acc_i_q <= sum_i_o;
      acc_q_q <= sum_q_o;
    end
  end
endmodule

// File: rtl/iq_amp_est.sv
module iq_amp_est #(
  parameter int ACC_W = 12,
  parameter int AMP_W = 12
) (
  input  logic [ACC_W-1:0] sum_i_i,
  input  logic [ACC_W-1:0] sum_q_i,
  output logic [AMP_W-1:0] amp_o
);
  logic [ACC_W-1:0] abs_i, abs_q, mx, mn;

  always_comb begin
    abs_i = sum_i_i[ACC_W-1] ? (~sum_i_i + 1'b1) : sum_i_i;
    abs_q = sum_q_i[ACC_W-1] ? (~sum_q_i + 1'b1) : sum_q_i;
    mx    = (abs_i >= abs_q) ? abs_i : abs_q;
    mn    = (abs_i >= abs_q) ? abs_q : abs_i;
    amp_o = AMP_W'(mx) + AMP_W'(mn >> 1);
  end
endmodule

// File: rtl/iq_bit_decide.sv
module iq_bit_decide #(
  parameter int AMP_W     = 12,
  parameter int AVG_SHIFT = 3,
  parameter int THRESH    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic             ks_en_i,
  input  logic             ks_bit_i,
  output logic             bit_o,
  output logic             done_o,
  output logic [AMP_W-1:0] amp_o
);
  logic det;

  assign det = (amp_i >> AVG_SHIFT) > AMP_W'(THRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o  <= 1'b0;
      done_o <= 1'b0;
      amp_o  <= '0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        bit_o <= det ^ (ks_en_i & ks_bit_i);
        amp_o <= amp_i;
      end
    end
  end
endmodule

// File: rtl/iq_env_bit_det.sv
module iq_env_bit_det #(
  parameter int SAMPLE_W = 8,
  parameter int SKIP_N   = 5,
  parameter int AVG_N    = 8,
  parameter int THRESH   = 8,
  localparam int AVG_SHIFT = $clog2(AVG_N),
  localparam int ACC_W     = SAMPLE_W + AVG_SHIFT + 1,
  localparam int AMP_W     = ACC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                win_start_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_i_i,
  input  logic [SAMPLE_W-1:0] smp_q_i,
  input  logic                ks_en_i,
  input  logic                ks_bit_i,
  output logic                bit_o,
  output logic                done_o,
  output logic [AMP_W-1:0]    amp_o
);
  logic [ACC_W-1:0] sum_i, sum_q;
  logic [AMP_W-1:0] amp;
  logic             last;

  iq_win_acc #(
    .SAMPLE_W(SAMPLE_W), .SKIP_N(SKIP_N), .AVG_N(AVG_N), .ACC_W(ACC_W)
  ) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(win_start_i), .valid_i(smp_valid_i),
    .i_i(smp_i_i), .q_i(smp_q_i), .sum_i_o(sum_i), .sum_q_o(sum_q), .last_o(last)
  );

  iq_amp_est #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_amp (
    .sum_i_i(sum_i), .sum_q_i(sum_q), .amp_o(amp)
  );

  iq_bit_decide #(.AMP_W(AMP_W), .AVG_SHIFT(AVG_SHIFT), .THRESH(THRESH)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(last), .amp_i(amp),
    .ks_en_i(ks_en_i), .ks_bit_i(ks_bit_i),
    .bit_o(bit_o), .done_o(done_o), .amp_o(amp_o)
  );
endmodule

// File: rtl/iq_env_bit_det_chk.sv
module iq_env_bit_det_chk #(
  parameter int SAMPLE_W = 8,
  parameter int AVG_N    = 8,
  parameter int THRESH   = 8,
  parameter int AMP_W    = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             win_start_i,
  input logic             smp_valid_i,
  input logic             ks_en_i,
  input logic             ks_bit_i,
  input logic             bit_o,
  input logic             done_o,
  input logic [AMP_W-1:0] amp_o
);
  localparam int SH      = $clog2(AVG_N);
  localparam int AMP_MAX = AVG_N * (2 ** (SAMPLE_W - 1)) * 3 / 2;

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(bit_o) && $stable(amp_o)));

  // R7 and R8: the decision agrees with the reported amplitude and keystream
  a_r7_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bit_o == (((int'(amp_o) >> SH) > THRESH) ^ $past(ks_en_i && ks_bit_i))));

  a_r6_amp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(amp_o) <= AMP_MAX));

  a_r2_done_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(smp_valid_i));

  a_r10_no_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(win_start_i));
endmodule

bind iq_env_bit_det iq_env_bit_det_chk #(
  .SAMPLE_W(SAMPLE_W), .AVG_N(AVG_N), .THRESH(THRESH), .AMP_W(AMP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_start_i(win_start_i), .smp_valid_i(smp_valid_i),
  .ks_en_i(ks_en_i), .ks_bit_i(ks_bit_i), .bit_o(bit_o), .done_o(done_o), .amp_o(amp_o)
);

// File: tb/tb_iq_env_bit_det.sv
`timescale 1ns/1ps
module tb_iq_env_bit_det;
  localparam int NV = 12;

  typedef struct packed {
    logic signed [7:0] iv;
    logic signed [7:0] qv;
    logic              ks_en;
    logic              ks;
    logic              gap;
    logic [11:0]       amp;
    logic              bitv;
  } vec_t;

  // summed pairs carry iv/qv; skipped and tail pairs carry large junk
  localparam vec_t VECS [NV] = '{
    '{ 8'sd20,    8'sd0,   1'b0, 1'b0, 1'b0, 12'd160,  1'b1},
    '{ 8'sd0,     8'sd0,   1'b0, 1'b0, 1'b1, 12'd0,    1'b0},
    '{-8'sd128,  -8'sd128, 1'b0, 1'b0, 1'b0, 12'd1536, 1'b1},
    '{ 8'sd9,     8'sd0,   1'b0, 1'b0, 1'b1, 12'd72,   1'b1},
    '{ 8'sd8,     8'sd1,   1'b0, 1'b0, 1'b0, 12'd68,   1'b0},
    '{ 8'sd8,     8'sd2,   1'b0, 1'b0, 1'b0, 12'd72,   1'b1},
    '{-8'sd5,     8'sd6,   1'b0, 1'b0, 1'b1, 12'd68,   1'b0},
    '{ 8'sd20,    8'sd0,   1'b1, 1'b1, 1'b0, 12'd160,  1'b0},
    '{ 8'sd0,     8'sd0,   1'b1, 1'b1, 1'b0, 12'd0,    1'b1},
    '{ 8'sd0,     8'sd0,   1'b0, 1'b1, 1'b0, 12'd0,    1'b0},
    '{ 8'sd127,  -8'sd3,   1'b0, 1'b0, 1'b1, 12'd1028, 1'b1},
    '{-8'sd1,    -8'sd1,   1'b0, 1'b0, 1'b0, 12'd12,   1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic win_start_i = 1'b0, smp_valid_i = 1'b0, ks_en_i = 1'b0, ks_bit_i = 1'b0;
  logic [7:0] smp_i_i = '0, smp_q_i = '0;
  logic bit_o, done_o;
  logic [11:0] amp_o;

  int checks = 0, failures = 0, done_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  iq_env_bit_det dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_start_i(win_start_i), .smp_valid_i(smp_valid_i),
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i), .ks_en_i(ks_en_i), .ks_bit_i(ks_bit_i),
    .bit_o(bit_o), .done_o(done_o), .amp_o(amp_o)
  );

  always @(negedge clk_i) if (done_o) done_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic drive_pair(input logic st, input logic [7:0] iv, input logic [7:0] qv);
    @(negedge clk_i);
    win_start_i = st;
    smp_valid_i = 1'b1;
    smp_i_i = iv;
    smp_q_i = qv;
  endtask

  task automatic idle_cycle();
    @(negedge clk_i);
    win_start_i = 1'b0;
    smp_valid_i = 1'b0;
    smp_i_i = 8'h55;
    smp_q_i = 8'hAA;
  endtask

  task automatic run_window(input vec_t v, input string tag);
    int d0;
    d0 = done_cnt;
    ks_en_i = v.ks_en;
    ks_bit_i = v.ks;
    for (int k = 0; k < 21; k++) begin
      if (k >= 5 && k < 13) drive_pair(k == 0, v.iv, v.qv);
      else drive_pair(k == 0, 8'sd120, -8'sd90);
      if (k == 12) begin
        @(posedge clk_i); #1;
        chk({tag, " R9 done"}, int'(done_o), 1);
        chk({tag, " R6 R4 R3 amp"}, int'(amp_o), int'(v.amp));
        chk({tag, " R7 R8 bit"}, int'(bit_o), int'(v.bitv));
      end
      if (k == 13) begin
        @(posedge clk_i); #1;
        chk({tag, " R9 single pulse"}, int'(done_o), 0);
      end
      if (v.gap) idle_cycle();
    end
    idle_cycle();
    idle_cycle();
    chk({tag, " R5 tail bit held"}, int'(bit_o), int'(v.bitv));
    chk({tag, " R5 tail amp held"}, int'(amp_o), int'(v.amp));
    chk({tag, " R5 one result"}, done_cnt - d0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 bit in reset", int'(bit_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 amp after reset", int'(amp_o), 0);
    chk("R1 done after reset", int'(done_o), 0);

    // R2: pairs before any strobe yield nothing
    for (int k = 0; k < 25; k++) drive_pair(1'b0, 8'sd100, 8'sd100);
    idle_cycle();
    idle_cycle();
    chk("R2 no result before strobe", done_cnt, 0);
    chk("R2 amp untouched", int'(amp_o), 0);

    for (int n = 0; n < NV; n++) run_window(VECS[n], $sformatf("vec%0d", n));

    // R10: restart mid-window discards partial sums
    run_window(VECS[0], "pre_restart");
    begin
      int d0;
      d0 = done_cnt;
      ks_en_i = 1'b0;
      for (int k = 0; k < 10; k++) drive_pair(k == 0, 8'sd120, 8'sd120);
      run_window('{8'sd0, 8'sd0, 1'b0, 1'b0, 1'b0, 12'd0, 1'b0}, "R10 restart");
      chk("R10 restart single result", done_cnt - d0, 1);
    end

    // R8: keystream bit ignored when disabled, held high through a strong window
    run_window('{8'sd30, 8'sd0, 1'b0, 1'b1, 1'b0, 12'd240, 1'b1}, "R8 ks off");
    summary();
  end
endmodule